// File: doc/BRIEF.md
# Overlapping-Word Nibble Check-Value Engine

This block walks a region of a byte-wide memory and reduces it to a 16-bit check value. The caller gives it a start address and a byte count and pulses `start`. The engine then reads bytes one at a time through a read port with a fixed one-cycle latency. It pairs each new byte with the byte before it to form a big-endian 16-bit word, and folds that word into an accumulator that begins at 0xFFFF. The fold is a nibble-mixing equation, not a bitwise polynomial division.

Because the word index steps by one byte, consecutive words share a byte. For the even part of the count, each step fetches only one new byte. If the count is odd, one extra fold runs on a word whose high byte is the byte at offset `even` and whose low byte is zero. The result stays on `result` after the one-cycle `done` pulse, until the next accepted start. Storing the value back to memory is left to the caller.

Top module: `crc_nib_engine`

## Requirements
- R1: After reset, and in the cycle after an accepted start, `result` is 0xFFFF. A `byte_count` of 0 completes with `result` = 0xFFFF.
- R2: Each fold maps (acc, w) to a new acc as follows. t = acc >> 8 and d = acc ^ w. lo = d[3:0] and hi = d[7:4] ^ lo. Then t ^= (lo<<3)|(lo<<8), and t ^= hi|(hi<<7)|(hi<<12). All values are kept to 16 bits.
- R3: Let E be `byte_count` with bit 0 cleared, and let m[] be memory. For i = 0 .. E-1 in rising order, the engine folds the word {m[start_addr+i], m[start_addr+i+1]}, with the first byte in bits 15:8.
- R4: When bit 0 of `byte_count` is 1, one final fold runs on {m[start_addr+E], 8'h00}.
- R5: Reads are issued on `rd_en`/`rd_addr`, and `rd_data` is taken in the following cycle. The addresses run consecutively from `start_addr` and wrap modulo 2^ADDR_W. Each address is read once. The number of reads L is E+1 when E>0, and bit 0 of `byte_count` otherwise. `rd_en` is high only while `busy`.
- R6: Count the start-accepting clock edge as edge 0. `done` is high in the cycle after edge L+1+(byte_count bit 0).
- R7: `start` is ignored while `busy` is high. A running job finishes with the result, read count and latency of its own arguments.
- R8: `done` is high for exactly one cycle, and `busy` falls together with it. `result` then holds its value until the next accepted start.
- R9: `busy` rises in the cycle after an accepted start and stays high through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| start_addr | input | ADDR_W | First byte address of the region |
| byte_count | input | CNT_W | Number of bytes in the region |
| busy | output | 1 | Job in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Check value accumulator |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 8 | Read data, valid one cycle after rd_en |

## Verification
The assertions assume that the memory returns `rd_data` exactly one cycle after each `rd_en`, and that `start_addr` and `byte_count` are stable in the cycle that `start` is accepted. They also assume that memory contents do not change during a job. The bench models the memory as a registered array that is filled once before the first job and never written afterwards. Its stimulus changes only at falling edges, and it raises a stray `start` with different arguments only while a job is running.

// File: rtl/crc_nib_pkg.sv
package crc_nib_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_TAIL  = 2'd2,
      ST_FIN   = 2'd3
   } eng_state_t;

   localparam logic [15:0] CRC_SEED = 16'hFFFF;

   // One fold step. Only the low byte of acc^word feeds the nibble mix;
   // the upper byte of the word cancels out of acc[15:8] below.
   function automatic logic [15:0] nib_fold(input logic [15:0] acc,
                                            input logic [15:0] word);
      logic [15:0] mix;
      logic [15:0] res;
      logic [3:0]  lo;
      logic [3:0]  hi;
      mix = acc ^ word;
      lo  = mix[3:0];
      hi  = mix[7:4] ^ lo;
      res = {8'h00, mix[15:8] ^ word[15:8]};
      res = res ^ (({12'h000, lo} << 3) | ({12'h000, lo} << 8));
      res = res ^ ({12'h000, hi} | ({12'h000, hi} << 7) | ({12'h000, hi} << 12));
      return res;
   endfunction

endpackage

// File: rtl/crc_nib_fetch.sv
module crc_nib_fetch #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              run,
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  total,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr
);

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;

   assign rd_en   = run && (left_q != '0);
   assign rd_addr = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
      end else if (load) begin
         addr_q <= base;
         left_q <= total;
      end else if (rd_en) begin
         addr_q <= addr_q + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/crc_nib_fold.sv
module crc_nib_fold
   import crc_nib_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        take,
   input  logic        first,
   input  logic        tail,
   input  logic [7:0]  byte_in,
   output logic [15:0] crc
);

   logic [7:0]  prev_q;
   logic [15:0] crc_q;

   assign crc = crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q  <= CRC_SEED;
         prev_q <= 8'h00;
      end else if (clear) begin
         crc_q  <= CRC_SEED;
         prev_q <= 8'h00;
      end else if (take) begin
         prev_q <= byte_in;
         if (!first) begin
            crc_q <= nib_fold(crc_q, {prev_q, byte_in});
         end
      end else if (tail) begin
         crc_q <= nib_fold(crc_q, {prev_q, 8'h00});
      end
   end

endmodule

// File: rtl/crc_nib_engine.sv
module crc_nib_engine
   import crc_nib_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  byte_count,
   output logic              busy,
   output logic              done,
   output logic [15:0]       result,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("crc_nib_engine: ADDR_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("crc_nib_engine: CNT_W must be at least 2");
      end
   endgenerate

   eng_state_t       state_q, state_d;
   logic             accept;
   logic             odd_q;
   logic             rvld_q;
   logic             first_q;
   logic [CNT_W-1:0] resp_left_q;
   logic [CNT_W-1:0] even_part;
   logic [CNT_W-1:0] read_total;
   logic             all_in;
   logic             take;

   assign accept    = start && (state_q == ST_IDLE);
   assign even_part = {byte_count[CNT_W-1:1], 1'b0};
   // even part > 0 needs even+1 bytes (bit 0 is clear so OR adds one)
   assign read_total = (even_part != '0) ? {byte_count[CNT_W-1:1], 1'b1}
                                         : {{(CNT_W-1){1'b0}}, byte_count[0]};

   assign take   = rvld_q && (state_q == ST_FETCH);
   assign all_in = (resp_left_q == '0) || (take && resp_left_q == {{(CNT_W-1){1'b0}}, 1'b1});

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_FETCH;
         ST_FETCH: if (all_in) state_d = odd_q ? ST_TAIL : ST_FIN;
         ST_TAIL:  state_d = ST_FIN;
         ST_FIN:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         odd_q       <= 1'b0;
         rvld_q      <= 1'b0;
         first_q     <= 1'b0;
         resp_left_q <= '0;
      end else begin
         state_q <= state_d;
         rvld_q  <= rd_en;
         if (accept) begin
            odd_q       <= byte_count[0];
            first_q     <= 1'b1;
            resp_left_q <= read_total;
         end else if (take) begin
            first_q     <= 1'b0;
            resp_left_q <= resp_left_q - 1'b1;
         end
      end
   end

   crc_nib_fetch #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) fetch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .run     (state_q == ST_FETCH),
      .base    (start_addr),
      .total   (read_total),
      .rd_en   (rd_en),
      .rd_addr (rd_addr)
   );

   crc_nib_fold fold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .take    (take),
      .first   (first_q),
      .tail    (state_q == ST_TAIL),
      .byte_in (rd_data),
      .crc     (result)
   );

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_FIN);

endmodule

// File: rtl/crc_nib_engine_chk.sv
module crc_nib_engine_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  byte_count,
   input logic              busy,
   input logic              done,
   input logic [15:0]       result,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr
);

   // R1: accepted start reloads the seed
   a_r1_seed_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && result == 16'hFFFF));

   // R5: no read outside a job
   a_r5_read_in_job: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> busy);

   // R5: back-to-back reads step the address by one
   a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

   // R7: a running job cannot be aborted or restarted
   a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R8: single-cycle done, busy drops with it
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R8: result is held while idle
   a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));

   // R9: done only inside a job
   a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R6: a zero-length job never reads
   a_r6_zero_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && byte_count == '0) |=> !rd_en);

endmodule

bind crc_nib_engine crc_nib_engine_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .byte_count (byte_count),
   .busy       (busy),
   .done       (done),
   .result     (result),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr)
);

// File: tb/crc_nib_engine_tb_top.sv
module crc_nib_engine_tb_top;

   localparam int AW = 8;
   localparam int CW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [CW-1:0] byte_count = '0;
   logic          busy, done, rd_en;
   logic [15:0]   result;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data;

   logic [7:0] mem [256];
   int n_tests = 0;
   int n_fail  = 0;
   int rd_seen = 0;

   always #5 clk = ~clk;

   crc_nib_engine #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_count(byte_count), .busy(busy), .done(done), .result(result),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always @(posedge clk) begin
      if (rd_en) begin
         rd_data <= mem[rd_addr];
         rd_seen <= rd_seen + 1;
      end
   end

   function automatic logic [15:0] ref_step(input logic [15:0] a, input logic [15:0] w);
      logic [15:0] t, d, lo, hi;
      t  = a >> 8;
      d  = a ^ w;
      lo = d & 16'h000F;
      hi = ((d >> 4) & 16'h000F) ^ lo;
      t  = t ^ ((lo << 3) | (lo << 8));
      t  = t ^ (hi | (hi << 7) | (hi << 12));
      return t;
   endfunction

   function automatic logic [15:0] ref_region(input int s, input int n);
      logic [15:0] acc;
      int e;
      acc = 16'hFFFF;
      e = n & ~1;
      for (int i = 0; i < e; i++)
         acc = ref_step(acc, {mem[(s + i) % 256], mem[(s + i + 1) % 256]});
      if (n % 2 == 1)
         acc = ref_step(acc, {mem[(s + e) % 256], 8'h00});
      return acc;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Runs one job; optionally raises a stray start while busy (R7)
   task automatic run_job(input int s, input int n, input bit stray, input string req);
      int e, nreads, lat, k;
      logic [15:0] exp_crc, held;
      e      = n & ~1;
      nreads = (e != 0) ? e + 1 : (n % 2);
      lat    = nreads + 1 + (n % 2);
      exp_crc = ref_region(s, n);
      @(negedge clk);
      start = 1'b1; start_addr = AW'(s); byte_count = CW'(n);
      rd_seen = 0;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R9", "busy after start", busy, 1);
      check(result == 16'hFFFF, "R1", "seed after start", result, 16'hFFFF);
      k = 0;
      while (!done && k < 3000) begin
         if (stray && k == 1) begin
            start = 1'b1; start_addr = AW'(s + 77); byte_count = CW'(0);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      check(done == 1'b1 && k == lat, req, "done latency", k, lat);
      check(result == exp_crc, req, "result", result, exp_crc);
      check(rd_seen == nreads, "R5", "read count", rd_seen, nreads);
      held = result;
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R8", "done/busy after pulse", {done, busy}, 0);
      repeat (3) @(negedge clk);
      check(result == held, "R8", "result held", result, held);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 53 + 17) ^ (i >> 3));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0 && rd_en == 1'b0, "R1", "idle after reset",
            {busy, done, rd_en}, 0);
      check(result == 16'hFFFF, "R1", "reset result", result, 16'hFFFF);

      run_job(10, 0, 1'b0, "R1");     // zero length
      run_job(20, 1, 1'b0, "R4");     // lone odd byte
      run_job(30, 2, 1'b0, "R3");     // single even step
      run_job(40, 3, 1'b0, "R4");     // even part plus tail
      run_job(5, 16, 1'b0, "R3");     // longer even region
      run_job(100, 33, 1'b0, "R2");   // long odd region
      run_job(250, 12, 1'b0, "R5");   // address wraps past the top
      run_job(251, 7, 1'b0, "R6");    // wrap with odd tail
      run_job(60, 9, 1'b1, "R7");     // stray start while busy

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule